// File: doc/BRIEF.md
# Shared Recovery-Lane Controller with Circulating Token

This controller sits in one router of a wormhole network whose adaptive routing may form cycles. Each router owns a single shared recovery buffer that joins the crossbar through one extra input port and can be filled by any neighbour. A one-bit token circulates on a ring of dedicated wires through every router. Only the router that holds the token may pull a blocked packet out of its normal path. The router streams that packet, flit by flit, from the edge buffer holding it into the recovery buffer of the next router on the packet's route. From then on the packet moves only through recovery buffers until it is ejected at its destination.

When recovery starts, the controller saves the crossbar connection it has to break: the input that currently owns the chosen output, and that output. It announces the break, forwards the packet, and then asks for the saved connection to be put back. The token stays in the router while the router is injecting, or while its own recovery buffer still holds flits, so the lane never carries two packets started by the same router. A router with nothing to do passes the token on after one cycle.

Flit format: bit FLIT_W-1 marks the tail, bit FLIT_W-2 marks the head, and the low ID_W bits of every flit carry the destination node number.

Top module: `dlb_ctrl`

## Requirements
- R1: With no deadlock flagged and an empty recovery buffer, a one-cycle pulse on `tok_i` gives a one-cycle pulse on `tok_o` in the next cycle.
- R2: A token that arrives while `dl_detect_i` is high is held. Recovery then starts: `xbar_brk_o` pulses for one cycle, with `xbar_in_o` and `xbar_out_o` showing the `xbar_cur_in_i` and `dl_out_port_i` values sampled when the token arrived.
- R3: During injection, each flit offered on the edge side appears unchanged on `rl_flit_o` with `rl_vld_o` high and `rl_port_o` equal to the saved output port. `edge_rdy_o` follows `rl_rdy_i`, so at most one flit moves per cycle and order is kept.
- R4: In the cycle after the tail flit (bit FLIT_W-1 set) is accepted, `xbar_rst_o` pulses for one cycle with the same saved ports. `tok_o` stays low until that pulse has passed and is raised within three cycles after it.
- R5: A held token is not released while the router's recovery buffer contains a flit. It is released within three cycles after the last flit has left.
- R6: The recovery buffer accepts flits from `db_in_*` up to DEPTH entries and lowers `db_in_rdy_o` when full.
- R7: A buffered flit whose low ID_W bits equal NODE_ID leaves on the eject channel with `rl_vld_o` and `db_sel_o` low. Any other buffered flit leaves on the recovery output with `db_sel_o` high and `rl_port_o` equal to `rt_port_i`.
- R8: One token visit allows at most one injection. If `dl_detect_i` stays high after an injection, the token is still released and no second `xbar_brk_o` follows.
- R9: `db_in_rdy_o` is low while an injection is in progress.
- R10: After reset, `tok_o`, `rl_vld_o`, `ej_vld_o`, `db_sel_o`, `xbar_brk_o` and `xbar_rst_o` are low and `db_in_rdy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dl_detect_i | input | 1 | A blocked packet at this router is flagged as deadlocked |
| dl_out_port_i | input | PW | Output port toward the next router on the blocked packet's route |
| xbar_cur_in_i | input | PW | Input port currently connected to that output |
| tok_i | input | 1 | Token from the previous router on the ring |
| tok_o | output | 1 | Token to the next router on the ring |
| edge_vld_i | input | 1 | Flit of the blocked packet valid at its edge buffer |
| edge_flit_i | input | FLIT_W | Flit from the blocked packet's edge buffer |
| edge_rdy_o | output | 1 | Edge flit taken onto the recovery lane |
| db_in_vld_i | input | 1 | Neighbour offers a flit to this router's recovery buffer |
| db_in_flit_i | input | FLIT_W | Flit from a neighbour |
| db_in_rdy_o | output | 1 | Recovery buffer can take a flit |
| rl_vld_o | output | 1 | Flit offered to a neighbour's recovery buffer |
| rl_flit_o | output | FLIT_W | Flit toward the neighbour |
| rl_port_o | output | PW | Neighbour port the flit goes to |
| rl_rdy_i | input | 1 | Neighbour recovery buffer accepts |
| rt_port_i | input | PW | Route result for the flit at the head of the recovery buffer |
| ej_vld_o | output | 1 | Flit ejected to the local node |
| ej_flit_o | output | FLIT_W | Ejected flit |
| ej_rdy_i | input | 1 | Local node accepts |
| db_sel_o | output | 1 | Recovery buffer is the crossbar source this cycle |
| xbar_brk_o | output | 1 | Pulse: break the saved crossbar connection |
| xbar_rst_o | output | 1 | Pulse: restore the saved crossbar connection |
| xbar_in_o | output | PW | Saved input port of the connection |
| xbar_out_o | output | PW | Saved output port of the connection |

## Verification
The bench targets the token hold while the recovery buffer is still full. A design that released the token there would let a second packet onto the lane, and the bench would see a `tok_o` pulse while flits wait. It stalls the downstream ready signal during injection to catch flits that are dropped or repeated. It also checks the restore pulse and the saved ports after the tail, which catches a wrong or missing restore. With the deadlock flag held high after recovery, a design that injected twice would show a second break pulse or keep the token. Flits addressed to the router itself must come out of the eject channel, which catches a destination compare that is inverted or taken from the wrong bits.

// File: rtl/dlb_pkg.sv
package dlb_pkg;

    typedef enum logic [1:0] {
        INJ_IDLE    = 2'd0,
        INJ_SEND    = 2'd1,
        INJ_RESTORE = 2'd2
    } inj_state_e;

    typedef struct packed {
        logic hold;
        logic used;
        logic tok;
    } tok_state_t;

endpackage

// File: rtl/dlb_fifo.sv
module dlb_fifo #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [FLIT_W-1:0] data_i,
    input  logic              pop_i,
    output logic [FLIT_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][FLIT_W-1:0] mem;
        logic [AW-1:0]                wp;
        logic [AW-1:0]                rp;
        logic [CW-1:0]                cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  do_push, do_pop;

    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CW'(DEPTH));
    assign head_o  = s_q.mem[s_q.rp];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.mem[s_q.wp] = data_i;
            s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (do_pop) begin
            s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R6: a lone accepted push grows the occupancy by exactly one
    assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && !full_o) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));
    // R6: a full buffer never accepts a flit
    assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_i && !pop_i) |=> full_o && $stable(s_q.wp));
endmodule

// File: rtl/dlb_token.sv
module dlb_token
    import dlb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tok_i,
    input  logic detect_i,
    input  logic buf_busy_i,
    input  logic inj_busy_i,
    output logic start_o,
    output logic tok_o
);
    tok_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.tok = 1'b0;
        start_o = 1'b0;
        if (!s_q.hold) begin
            if (tok_i) begin
                if (detect_i || buf_busy_i) begin
                    s_d.hold = 1'b1;
                    s_d.used = 1'b0;
                end else begin
                    s_d.tok = 1'b1;
                end
            end
        end else if (!s_q.used && detect_i && !buf_busy_i && !inj_busy_i) begin
            start_o  = 1'b1;
            s_d.used = 1'b1;
        end else if (!inj_busy_i && !buf_busy_i && (s_q.used || !detect_i)) begin
            s_d.hold = 1'b0;
            s_d.tok  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign tok_o = s_q.tok;

    // R1: an idle router forwards the token in the next cycle
    assert_tok_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tok_i && !s_q.hold && !detect_i && !buf_busy_i) |=> tok_o);
    // R5: no release while the recovery buffer still holds flits
    assert_tok_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.hold && buf_busy_i) |=> !tok_o);
    // R8: a router that has injected once cannot start again on the same visit
    assert_single_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);
endmodule

// File: rtl/dlb_inject.sv
module dlb_inject
    import dlb_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [PW-1:0] cur_in_i,
    input  logic [PW-1:0] out_port_i,
    input  logic          xfer_i,
    input  logic          tail_i,
    output logic          active_o,
    output logic          busy_o,
    output logic          brk_o,
    output logic          restore_o,
    output logic [PW-1:0] sv_in_o,
    output logic [PW-1:0] sv_out_o
);
    typedef struct packed {
        inj_state_e    st;
        logic          brk;
        logic [PW-1:0] sv_in;
        logic [PW-1:0] sv_out;
    } inj_t;

    inj_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.brk = 1'b0;
        unique case (s_q.st)
            INJ_IDLE: begin
                if (start_i) begin
                    s_d.st     = INJ_SEND;
                    s_d.brk    = 1'b1;
                    s_d.sv_in  = cur_in_i;
                    s_d.sv_out = out_port_i;
                end
            end
            INJ_SEND: begin
                if (xfer_i && tail_i) s_d.st = INJ_RESTORE;
            end
            INJ_RESTORE: s_d.st = INJ_IDLE;
            default:     s_d.st = INJ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: INJ_IDLE, default: '0};
        else         s_q <= s_d;
    end

    assign active_o  = (s_q.st == INJ_SEND);
    assign busy_o    = (s_q.st != INJ_IDLE);
    assign restore_o = (s_q.st == INJ_RESTORE);
    assign brk_o     = s_q.brk;
    assign sv_in_o   = s_q.sv_in;
    assign sv_out_o  = s_q.sv_out;

    // R2: the break request is a single-cycle pulse
    assert_brk_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |=> !brk_o);
    // R4: the restore request follows the accepted tail
    assert_restore_after_tail_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && xfer_i && tail_i) |=> restore_o);
    // R4: saved ports do not move between break and restore
    assert_saved_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !start_i) |=> $stable(sv_in_o) && $stable(sv_out_o));
endmodule

// File: rtl/dlb_ctrl.sv
module dlb_ctrl
    import dlb_pkg::*;
#(
    parameter int FLIT_W  = 16,
    parameter int ID_W    = 4,
    parameter int NODE_ID = 3,
    parameter int NPORT   = 5,
    parameter int DEPTH   = 2,
    localparam int PW     = $clog2(NPORT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dl_detect_i,
    input  logic [PW-1:0]     dl_out_port_i,
    input  logic [PW-1:0]     xbar_cur_in_i,
    input  logic              tok_i,
    output logic              tok_o,
    input  logic              edge_vld_i,
    input  logic [FLIT_W-1:0] edge_flit_i,
    output logic              edge_rdy_o,
    input  logic              db_in_vld_i,
    input  logic [FLIT_W-1:0] db_in_flit_i,
    output logic              db_in_rdy_o,
    output logic              rl_vld_o,
    output logic [FLIT_W-1:0] rl_flit_o,
    output logic [PW-1:0]     rl_port_o,
    input  logic              rl_rdy_i,
    input  logic [PW-1:0]     rt_port_i,
    output logic              ej_vld_o,
    output logic [FLIT_W-1:0] ej_flit_o,
    input  logic              ej_rdy_i,
    output logic              db_sel_o,
    output logic              xbar_brk_o,
    output logic              xbar_rst_o,
    output logic [PW-1:0]     xbar_in_o,
    output logic [PW-1:0]     xbar_out_o
);
    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);
    localparam int TAIL_BIT = FLIT_W - 1;

    logic              fifo_empty, fifo_full, fifo_pop;
    logic [FLIT_W-1:0] fifo_head;
    logic              head_mine, buffered;
    logic              inj_active, inj_busy, tok_start;
    logic [PW-1:0]     inj_port;

    dlb_fifo #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_buf (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (db_in_vld_i && db_in_rdy_o),
        .data_i  (db_in_flit_i),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    dlb_token u_tok (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tok_i      (tok_i),
        .detect_i   (dl_detect_i),
        .buf_busy_i (!fifo_empty),
        .inj_busy_i (inj_busy),
        .start_o    (tok_start),
        .tok_o      (tok_o)
    );

    dlb_inject #(.PW(PW)) u_inj (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (tok_start),
        .cur_in_i   (xbar_cur_in_i),
        .out_port_i (dl_out_port_i),
        .xfer_i     (edge_vld_i && edge_rdy_o),
        .tail_i     (edge_flit_i[TAIL_BIT]),
        .active_o   (inj_active),
        .busy_o     (inj_busy),
        .brk_o      (xbar_brk_o),
        .restore_o  (xbar_rst_o),
        .sv_in_o    (xbar_in_o),
        .sv_out_o   (inj_port)
    );

    assign xbar_out_o  = inj_port;
    assign head_mine   = (fifo_head[ID_W-1:0] == MY_ID);
    assign buffered    = !inj_active && !fifo_empty;

    assign rl_vld_o    = inj_active ? edge_vld_i : (buffered && !head_mine);
    assign rl_flit_o   = inj_active ? edge_flit_i : fifo_head;
    assign rl_port_o   = inj_active ? inj_port : rt_port_i;
    assign edge_rdy_o  = inj_active && rl_rdy_i;
    assign db_sel_o    = buffered && !head_mine;
    assign ej_vld_o    = buffered && head_mine;
    assign ej_flit_o   = fifo_head;
    assign fifo_pop    = buffered && (head_mine ? ej_rdy_i : rl_rdy_i);
    assign db_in_rdy_o = !fifo_full && !inj_active;

    // R7: a flit is never offered to both sinks from the buffer
    assert_one_sink_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ej_vld_o |-> !db_sel_o && !rl_vld_o);
    // R7: a stalled buffered flit stays put on the recovery output
    assert_hold_flit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (db_sel_o && !rl_rdy_i) |=> db_sel_o && $stable(rl_flit_o));
    // R9: neighbours are held off while this router injects
    assert_in_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inj_active |-> !db_in_rdy_o);
    // R4: the token never leaves while the restore is being issued
    assert_no_tok_on_restore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xbar_rst_o |-> !tok_o);
endmodule

// File: tb/dlb_ctrl_tb.sv
module dlb_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FLIT_W = 16;
    localparam int ID_W   = 4;
    localparam int NODE_ID = 3;
    localparam int NPORT  = 5;
    localparam int DEPTH  = 2;
    localparam int PW     = $clog2(NPORT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dl_detect = 1'b0;
    logic [PW-1:0] dl_out_port = '0, xbar_cur_in = '0, rt_port = '0;
    logic tok_in = 1'b0, tok_out;
    logic edge_vld = 1'b0, edge_rdy;
    logic [FLIT_W-1:0] edge_flit = '0;
    logic db_in_vld = 1'b0, db_in_rdy;
    logic [FLIT_W-1:0] db_in_flit = '0;
    logic rl_vld, rl_rdy = 1'b0;
    logic [FLIT_W-1:0] rl_flit, ej_flit;
    logic [PW-1:0] rl_port, xb_in, xb_out;
    logic ej_vld, ej_rdy = 1'b0;
    logic db_sel, xb_brk, xb_rst;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlb_ctrl #(.FLIT_W(FLIT_W), .ID_W(ID_W), .NODE_ID(NODE_ID), .NPORT(NPORT), .DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .dl_detect_i(dl_detect), .dl_out_port_i(dl_out_port),
        .xbar_cur_in_i(xbar_cur_in), .tok_i(tok_in), .tok_o(tok_out),
        .edge_vld_i(edge_vld), .edge_flit_i(edge_flit), .edge_rdy_o(edge_rdy),
        .db_in_vld_i(db_in_vld), .db_in_flit_i(db_in_flit), .db_in_rdy_o(db_in_rdy),
        .rl_vld_o(rl_vld), .rl_flit_o(rl_flit), .rl_port_o(rl_port), .rl_rdy_i(rl_rdy),
        .rt_port_i(rt_port), .ej_vld_o(ej_vld), .ej_flit_o(ej_flit), .ej_rdy_i(ej_rdy),
        .db_sel_o(db_sel), .xbar_brk_o(xb_brk), .xbar_rst_o(xb_rst),
        .xbar_in_o(xb_in), .xbar_out_o(xb_out)
    );

    function automatic logic [FLIT_W-1:0] mk(input logic hd, input logic tl,
                                             input logic [7:0] pay, input logic [ID_W-1:0] dst);
        return {tl, hd, 2'b00, pay, dst};
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check(tok_out == 0, "R10 tok_o", 32'(tok_out), 0);
        check(rl_vld == 0 && ej_vld == 0, "R10 valids", {30'd0, rl_vld, ej_vld}, 0);
        check(db_sel == 0 && xb_brk == 0 && xb_rst == 0, "R10 xbar", {29'd0, db_sel, xb_brk, xb_rst}, 0);
        check(db_in_rdy == 1, "R10 db_in_rdy", 32'(db_in_rdy), 1);
    endtask

    task automatic t_pass();
        step(); tok_in = 1'b1;
        step(); tok_in = 1'b0; #1;
        check(tok_out == 1, "R1 token forwarded", 32'(tok_out), 1);
        step(); #1;
        check(tok_out == 0, "R1 single pulse", 32'(tok_out), 0);
    endtask

    task automatic t_inject(input logic keep_detect);
        logic [FLIT_W-1:0] f [3];
        int idx;
        logic got;
        f[0] = mk(1, 0, 8'hA1, 4'd9);
        f[1] = mk(0, 0, 8'hB2, 4'd9);
        f[2] = mk(0, 1, 8'hC3, 4'd9);
        step(); dl_detect = 1'b1; dl_out_port = 3'd2; xbar_cur_in = 3'd4; tok_in = 1'b1;
        step(); tok_in = 1'b0; #1;
        check(tok_out == 0, "R2 token held", 32'(tok_out), 0);
        step(); xbar_cur_in = 3'd1; dl_out_port = 3'd0; #1;
        check(xb_brk == 1, "R2 break pulse", 32'(xb_brk), 1);
        check(xb_in == 3'd4 && xb_out == 3'd2, "R2 saved ports", {26'd0, xb_in, xb_out}, {26'd0, 3'd4, 3'd2});
        idx = 0;
        for (int cyc = 0; cyc < 40 && idx < 3; cyc++) begin
            step();
            edge_vld = 1'b1; edge_flit = f[idx]; rl_rdy = cyc[0];
            #1;
            if (cyc == 0) check(xb_brk == 0, "R2 break one cycle", 32'(xb_brk), 0);
            check(db_in_rdy == 0, "R9 input blocked", 32'(db_in_rdy), 0);
            check(tok_out == 0, "R4 token kept during send", 32'(tok_out), 0);
            check(edge_rdy == rl_rdy, "R3 ready follows", 32'(edge_rdy), 32'(rl_rdy));
            if (edge_rdy) begin
                check(rl_vld && rl_flit == f[idx], "R3 flit order", 32'(rl_flit), 32'(f[idx]));
                check(rl_port == 3'd2, "R3 lane port", 32'(rl_port), 2);
                idx++;
            end
        end
        step(); edge_vld = 1'b0; rl_rdy = 1'b0; dl_detect = keep_detect; #1;
        check(xb_rst == 1, "R4 restore pulse", 32'(xb_rst), 1);
        check(xb_in == 3'd4 && xb_out == 3'd2, "R4 restore ports", {26'd0, xb_in, xb_out}, {26'd0, 3'd4, 3'd2});
        check(tok_out == 0, "R4 no token with restore", 32'(tok_out), 0);
        got = 1'b0;
        for (int i = 0; i < 3 && !got; i++) begin
            step(); #1;
            if (i == 0) check(xb_rst == 0, "R4 restore one cycle", 32'(xb_rst), 0);
            got = tok_out;
        end
        check(got == 1, "R4 token released", 32'(got), 1);
        if (keep_detect) begin
            for (int i = 0; i < 5; i++) begin
                step(); #1;
                check(xb_brk == 0 && tok_out == 0, "R8 single injection", {30'd0, xb_brk, tok_out}, 0);
            end
        end
        dl_detect = 1'b0;
    endtask

    task automatic t_transit();
        logic [FLIT_W-1:0] f [2];
        logic got;
        int idx;
        f[0] = mk(1, 0, 8'h11, 4'd7);
        f[1] = mk(0, 1, 8'h22, 4'd7);
        rt_port = 3'd3;
        for (int i = 0; i < 2; i++) begin
            step(); db_in_vld = 1'b1; db_in_flit = f[i]; #1;
            check(db_in_rdy == 1, "R6 space available", 32'(db_in_rdy), 1);
        end
        step(); db_in_vld = 1'b0; #1;
        check(db_in_rdy == 0, "R6 full stops input", 32'(db_in_rdy), 0);
        step(); tok_in = 1'b1;
        step(); tok_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(); #1;
            check(tok_out == 0, "R5 held while buffered", 32'(tok_out), 0);
            check(db_sel && rl_vld && rl_flit == f[0], "R7 stalled head", 32'(rl_flit), 32'(f[0]));
        end
        idx = 0;
        for (int cyc = 0; cyc < 10 && idx < 2; cyc++) begin
            step(); rl_rdy = 1'b1; #1;
            check(db_sel == 1 && rl_port == 3'd3, "R7 forward port", 32'(rl_port), 3);
            check(rl_flit == f[idx], "R7 forward flit", 32'(rl_flit), 32'(f[idx]));
            check(tok_out == 0, "R5 held until empty", 32'(tok_out), 0);
            idx++;
        end
        step(); rl_rdy = 1'b0;
        got = tok_out;
        for (int i = 0; i < 3 && !got; i++) begin
            step(); #1; got = tok_out;
        end
        check(got == 1, "R5 token after drain", 32'(got), 1);
    endtask

    task automatic t_eject();
        logic [FLIT_W-1:0] f;
        f = mk(1, 1, 8'h5C, 4'(NODE_ID));
        step(); db_in_vld = 1'b1; db_in_flit = f;
        step(); db_in_vld = 1'b0; #1;
        check(ej_vld == 1 && ej_flit == f, "R7 eject local", 32'(ej_flit), 32'(f));
        check(rl_vld == 0 && db_sel == 0, "R7 not forwarded", {30'd0, rl_vld, db_sel}, 0);
        step(); ej_rdy = 1'b1;
        step(); ej_rdy = 1'b0; #1;
        check(ej_vld == 0, "R7 eject drained", 32'(ej_vld), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pass();
        t_inject(1'b0);
        t_transit();
        t_eject();
        t_inject(1'b1);
        t_pass();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule